// File: doc/BRIEF.md
# Beat-Sequenced Predicated Vector Adder

This block adds two 128-bit packed vectors lane by lane, treating the vector as sixteen 8-bit, eight 16-bit or four 32-bit lanes. The datapath is only one or two 32-bit beats wide, so each vector is processed as a series of beats over several cycles. The beats come out one group per cycle, starting at beat 0, and each group carries its own byte-enable mask.

A loop sequencer takes a total element count and a lane-size code when `start` is pulsed. It then issues one vector step after another, and each step removes one vector's worth of lanes from the remaining count. At every step a tail predicate allows only the lanes whose index is below the remaining count. The last, partly filled vector is therefore handled by masking, with no scalar clean-up pass.

The surrounding logic watches `issue` and presents the operands for the next step. The operands are captured on the clock edge that ends a cycle in which `issue` is high.

Top module: `vbeat_add_unit`

## Requirements
- R1: The lane-size code selects the lane width: 0 gives sixteen 8-bit lanes, 1 gives eight 16-bit lanes, and 2 or 3 give four 32-bit lanes. Each active lane holds the sum of its two operand lanes modulo 2 to the power of the lane width, and no carry crosses a lane boundary. Lane i occupies the bits starting at i times the lane width.
- R2: A vector is delivered as 4/BEATS_PER_CYC result groups on consecutive cycles. Each group holds BEATS_PER_CYC beats of 32 bits, and beat k of the vector sits in bits 32k upward. The first group appears two cycles after the issuing edge.
- R3: Within a vector the groups come out in ascending beat order. `res_beat` gives the index of the lowest beat in the group, and `res_last` is high only on the group that holds beat 3.
- R4: A lane is active exactly when its lane index is less than the count that remains at the step that issues it.
- R5: Byte-enable bit j covers result byte j. All bytes of an active lane are enabled. An inactive lane has all its bytes disabled and reads as zero on `res_data`.
- R6: After each step the remaining count drops by the number of lanes for the current size, or goes to zero if fewer lanes remain. A count n therefore produces ceil(n / lanes) vector steps.
- R7: Steps issue back to back, one every 4/BEATS_PER_CYC cycles. The first step issues in the cycle after `start` is accepted.
- R8: `done` is a one-cycle pulse in the cycle after the step that brought the count to zero. A start with a count of zero issues no step, produces no result group, and pulses `done` in the cycle after `start`.
- R9: While a loop is running, `start`, `cnt_in` and `lane_sz` are ignored. The number of steps and the `done` timing stay those of the accepted request.
- R10: During and just after a synchronous reset, `issue`, `res_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a new loop when idle |
| cnt_in | input | CNT_W | Total element count |
| lane_sz | input | 2 | Lane-size code |
| opnd_a | input | VLEN | First operand vector, captured on an issuing edge |
| opnd_b | input | VLEN | Second operand vector, captured on an issuing edge |
| issue | output | 1 | A step is issued at the coming edge |
| res_valid | output | 1 | Result group valid |
| res_last | output | 1 | Group holds the final beat of a vector |
| res_beat | output | log2(VLEN/BEAT_W) | Index of the lowest beat in the group |
| res_data | output | BEATS_PER_CYC*BEAT_W | Result group data |
| res_be | output | BEATS_PER_CYC*BEAT_W/8 | Byte enables of the group |
| done | output | 1 | Loop finished pulse |

## Verification
A wrong remaining count shows up in the byte-enable mask of the next vector. That mask is visible two cycles after the issuing edge, and the same error also changes the number of steps and moves the `done` pulse. A beat counter that skips or stalls causes a group with the wrong `res_beat` or misplaced data on the very next cycle. A broken carry link shows up as a wrong sum in the first group whose lane holds the affected byte pair. For that reason the sweeps include all-ones operands that carry across every byte. Both the single-beat and the dual-beat configurations are driven with the same requests, and every count is checked against its exact latency.

// File: rtl/vbeat_pkg.sv
package vbeat_pkg;

    // Lane-size code; the top code value also means 32-bit lanes
    typedef enum logic [1:0] {
        LSZ_8   = 2'd0,
        LSZ_16  = 2'd1,
        LSZ_32  = 2'd2,
        LSZ_32X = 2'd3
    } lane_sz_e;

    typedef enum logic {
        LC_IDLE = 1'b0,
        LC_RUN  = 1'b1
    } loop_st_e;

    // Issued step as handed from the sequencer to the beat engine
    typedef struct packed {
        logic     live;
        lane_sz_e sz;
    } step_ctl_t;

    // log2 of the lane width in bytes
    function automatic int unsigned lane_shift(lane_sz_e s);
        case (s)
            LSZ_8:   return 0;
            LSZ_16:  return 1;
            default: return 2;
        endcase
    endfunction

    function automatic int unsigned lane_bytes(lane_sz_e s);
        return 32'd1 << lane_shift(s);
    endfunction

    // True when byte_idx and byte_idx+1 belong to the same lane
    function automatic logic carry_link(lane_sz_e s, int unsigned byte_idx);
        return ((byte_idx + 1) % lane_bytes(s)) != 0;
    endfunction

endpackage

// File: rtl/vbeat_lane_add.sv
module vbeat_lane_add
    import vbeat_pkg::*;
#(
    parameter int BEAT_W = 32
) (
    input  logic [BEAT_W-1:0]   a,
    input  logic [BEAT_W-1:0]   b,
    input  lane_sz_e            sz,
    input  logic [BEAT_W/8-1:0] en,
    output logic [BEAT_W-1:0]   y
);
    localparam int NB = BEAT_W / 8;

    // carry into each byte; links are cut at lane boundaries
    logic [NB-1:0] cy;

    assign cy[0] = 1'b0;

    generate
        for (genvar i = 0; i < NB; i++) begin : g_byte
            logic [8:0] t;
            assign t = {1'b0, a[8*i +: 8]} + {1'b0, b[8*i +: 8]} + {8'b0, cy[i]};
            assign y[8*i +: 8] = en[i] ? t[7:0] : 8'h00;
            if (i < NB - 1) begin : g_link
                assign cy[i+1] = carry_link(sz, i) ? t[8] : 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/vbeat_tail_pred.sv
module vbeat_tail_pred
    import vbeat_pkg::*;
#(
    parameter int NBYTES = 16,
    parameter int CNT_W  = 16
) (
    input  logic [CNT_W-1:0]  rem,
    input  lane_sz_e          sz,
    output logic [NBYTES-1:0] be
);
    // byte k belongs to lane k >> shift; enabled when that lane index < rem
    always_comb begin
        for (int k = 0; k < NBYTES; k++) begin
            be[k] = (CNT_W'(k >> lane_shift(sz)) < rem);
        end
    end

endmodule

// File: rtl/vbeat_loop_ctl.sv
module vbeat_loop_ctl
    import vbeat_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NBYTES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt_in,
    input  lane_sz_e         sz_in,
    input  logic             exec_ready,
    output logic             issue,
    output logic [CNT_W-1:0] iss_rem,
    output step_ctl_t        iss_ctl,
    output logic             done
);
    loop_st_e         st;
    lane_sz_e         sz_q;
    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] rem_nx;

    assign step    = CNT_W'(NBYTES >> lane_shift(sz_q));
    assign rem_nx  = (rem > step) ? (rem - step) : '0;
    assign issue   = (st == LC_RUN) && exec_ready;
    assign iss_rem = rem;
    assign iss_ctl = '{live: issue, sz: sz_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LC_IDLE;
            sz_q <= LSZ_8;
            rem  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                LC_IDLE: begin
                    if (start) begin
                        sz_q <= sz_in;
                        if (cnt_in == '0) begin
                            done <= 1'b1;
                        end else begin
                            rem <= cnt_in;
                            st  <= LC_RUN;
                        end
                    end
                end
                LC_RUN: begin
                    if (issue) begin
                        rem <= rem_nx;
                        if (rem_nx == '0) begin
                            st   <= LC_IDLE;
                            done <= 1'b1;
                        end
                    end
                end
                default: st <= LC_IDLE;
            endcase
        end
    end

    // R4: a step is never issued with nothing left
    p_issue_live_r4: assert property (@(posedge clk) disable iff (rst)
        issue |-> rem != '0);

    // R6: every step strictly lowers the remaining count
    p_count_falls_r6: assert property (@(posedge clk) disable iff (rst)
        issue |=> rem < $past(rem));

    // R8: done only once the count is exhausted and the loop is idle
    p_done_empty_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (st == LC_IDLE) && (rem == '0));

    // R9: a running loop keeps its request while no step issues
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (st == LC_RUN && !issue) |=> $stable(rem) && $stable(sz_q));

endmodule

// File: rtl/vbeat_exec.sv
module vbeat_exec
    import vbeat_pkg::*;
#(
    parameter int VLEN   = 128,
    parameter int BEAT_W = 32,
    parameter int BPC    = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  step_ctl_t                 step_in,
    input  logic [VLEN-1:0]           a,
    input  logic [VLEN-1:0]           b,
    input  logic [VLEN/8-1:0]         pbe,
    output logic                      ready,
    output logic                      o_valid,
    output logic                      o_last,
    output logic [$clog2(VLEN/BEAT_W)-1:0] o_beat,
    output logic [BPC*BEAT_W-1:0]     o_data,
    output logic [BPC*BEAT_W/8-1:0]   o_be
);
    localparam int NBEATS = VLEN / BEAT_W;
    localparam int NBYTES = VLEN / 8;
    localparam int NBB    = BEAT_W / 8;
    localparam int CPV    = NBEATS / BPC;
    localparam int GRP_W  = (CPV > 1) ? $clog2(CPV) : 1;
    localparam int BIDX_W = $clog2(NBEATS);

    logic              busy;
    logic [GRP_W-1:0]  bcnt;
    logic [VLEN-1:0]   opa;
    logic [VLEN-1:0]   opb;
    logic [NBYTES-1:0] pbe_q;
    lane_sz_e          sz_q;
    logic              at_end;
    logic [BIDX_W-1:0] grp_base;

    logic [BPC*BEAT_W-1:0] sum_w;
    logic [BPC*NBB-1:0]    en_w;

    assign at_end   = (bcnt == GRP_W'(CPV - 1));
    assign ready    = !busy || at_end;
    assign grp_base = BIDX_W'(int'(bcnt) * BPC);

    generate
        for (genvar j = 0; j < BPC; j++) begin : g_lane
            logic [BIDX_W-1:0] sel;
            assign sel = BIDX_W'(int'(bcnt) * BPC + j);
            assign en_w[j*NBB +: NBB] = pbe_q[int'(sel)*NBB +: NBB];
            vbeat_lane_add #(.BEAT_W(BEAT_W)) u_add (
                .a  (opa[int'(sel)*BEAT_W +: BEAT_W]),
                .b  (opb[int'(sel)*BEAT_W +: BEAT_W]),
                .sz (sz_q),
                .en (pbe_q[int'(sel)*NBB +: NBB]),
                .y  (sum_w[j*BEAT_W +: BEAT_W])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            bcnt    <= '0;
            opa     <= '0;
            opb     <= '0;
            pbe_q   <= '0;
            sz_q    <= LSZ_8;
            o_valid <= 1'b0;
            o_last  <= 1'b0;
            o_beat  <= '0;
            o_data  <= '0;
            o_be    <= '0;
        end else begin
            o_valid <= busy;
            o_last  <= busy && at_end;
            o_beat  <= busy ? grp_base : '0;
            o_data  <= busy ? sum_w : '0;
            o_be    <= busy ? en_w : '0;
            if (step_in.live) begin
                busy  <= 1'b1;
                bcnt  <= '0;
                opa   <= a;
                opb   <= b;
                pbe_q <= pbe;
                sz_q  <= step_in.sz;
            end else if (busy) begin
                if (at_end) begin
                    busy <= 1'b0;
                end else begin
                    bcnt <= bcnt + 1'b1;
                end
            end
        end
    end

    // R3: groups of one vector follow each other in ascending beat order
    p_beat_order_r3: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_last) |=> o_valid && (o_beat == BIDX_W'(int'($past(o_beat)) + BPC)));

    // R2: the first group appears two cycles after the issuing edge
    p_first_group_r2: assert property (@(posedge clk) disable iff (rst)
        step_in.live |-> ##2 (o_valid && o_beat == '0));

    generate
        for (genvar k = 0; k < BPC*NBB; k++) begin : g_chk_byte
            // R5: disabled bytes carry zero
            p_dead_byte_zero_r5: assert property (@(posedge clk) disable iff (rst)
                (o_valid && !o_be[k]) |-> o_data[8*k +: 8] == 8'h00);
        end
        for (genvar k = 0; k < NBYTES - 1; k++) begin : g_chk_prefix
            // R4: the enabled bytes form a prefix of the vector
            p_pred_prefix_r4: assert property (@(posedge clk) disable iff (rst)
                (busy && pbe_q[k+1]) |-> pbe_q[k]);
        end
        for (genvar m = 0; m < NBYTES / 2; m++) begin : g_chk_half
            // R5: a 16-bit lane is enabled as a whole
            p_half_whole_r5: assert property (@(posedge clk) disable iff (rst)
                (busy && sz_q == LSZ_16) |-> pbe_q[2*m] == pbe_q[2*m+1]);
        end
        for (genvar m = 0; m < NBYTES / 4; m++) begin : g_chk_word
            // R5: a 32-bit lane is enabled as a whole
            p_word_whole_r5: assert property (@(posedge clk) disable iff (rst)
                (busy && (sz_q == LSZ_32 || sz_q == LSZ_32X))
                    |-> (pbe_q[4*m +: 4] == 4'h0 || pbe_q[4*m +: 4] == 4'hF));
        end
    endgenerate

endmodule

// File: rtl/vbeat_add_unit.sv
module vbeat_add_unit
    import vbeat_pkg::*;
#(
    parameter int VLEN          = 128,
    parameter int BEAT_W        = 32,
    parameter int BEATS_PER_CYC = 1,
    parameter int CNT_W         = 16
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   start,
    input  logic [CNT_W-1:0]                       cnt_in,
    input  logic [1:0]                             lane_sz,
    input  logic [VLEN-1:0]                        opnd_a,
    input  logic [VLEN-1:0]                        opnd_b,
    output logic                                   issue,
    output logic                                   res_valid,
    output logic                                   res_last,
    output logic [$clog2(VLEN/BEAT_W)-1:0]         res_beat,
    output logic [BEATS_PER_CYC*BEAT_W-1:0]        res_data,
    output logic [BEATS_PER_CYC*BEAT_W/8-1:0]      res_be,
    output logic                                   done
);
    localparam int NBYTES = VLEN / 8;

    logic              exec_ready;
    logic [CNT_W-1:0]  iss_rem;
    step_ctl_t         iss_ctl;
    logic [NBYTES-1:0] pred_be;

    vbeat_loop_ctl #(
        .CNT_W  (CNT_W),
        .NBYTES (NBYTES)
    ) u_loop (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cnt_in     (cnt_in),
        .sz_in      (lane_sz_e'(lane_sz)),
        .exec_ready (exec_ready),
        .issue      (issue),
        .iss_rem    (iss_rem),
        .iss_ctl    (iss_ctl),
        .done       (done)
    );

    vbeat_tail_pred #(
        .NBYTES (NBYTES),
        .CNT_W  (CNT_W)
    ) u_pred (
        .rem (iss_rem),
        .sz  (iss_ctl.sz),
        .be  (pred_be)
    );

    vbeat_exec #(
        .VLEN   (VLEN),
        .BEAT_W (BEAT_W),
        .BPC    (BEATS_PER_CYC)
    ) u_exec (
        .clk     (clk),
        .rst     (rst),
        .step_in (iss_ctl),
        .a       (opnd_a),
        .b       (opnd_b),
        .pbe     (pred_be),
        .ready   (exec_ready),
        .o_valid (res_valid),
        .o_last  (res_last),
        .o_beat  (res_beat),
        .o_data  (res_data),
        .o_be    (res_be)
    );

    // R10: no output activity while reset is held
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> !res_valid && !done);

endmodule

// File: tb/vbeat_add_unit_tb_top.sv
`timescale 1ns/1ps
module vbeat_add_unit_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst, start;
    logic [15:0]  cnt;
    logic [1:0]   sz;
    logic [127:0] a0, b0, a1, b1;
    logic         iss0, iss1, v0, v1, l0, l1, dn0, dn1;
    logic [1:0]   bt0, bt1;
    logic [31:0]  dt0;
    logic [63:0]  dt1;
    logic [3:0]   be0;
    logic [7:0]   be1;

    vbeat_add_unit #(.BEATS_PER_CYC(1)) dut_i (
        .clk(clk), .rst(rst), .start(start), .cnt_in(cnt), .lane_sz(sz),
        .opnd_a(a0), .opnd_b(b0), .issue(iss0), .res_valid(v0), .res_last(l0),
        .res_beat(bt0), .res_data(dt0), .res_be(be0), .done(dn0));

    vbeat_add_unit #(.BEATS_PER_CYC(2)) dut2_i (
        .clk(clk), .rst(rst), .start(start), .cnt_in(cnt), .lane_sz(sz),
        .opnd_a(a1), .opnd_b(b1), .issue(iss1), .res_valid(v1), .res_last(l1),
        .res_beat(bt1), .res_data(dt1), .res_be(be1), .done(dn1));

    int checks = 0;
    int fails  = 0;
    int cur_n, cur_sz, cur_seed;
    int g0, g1;
    logic stop0, stop1;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int lanes(input int s);
        return (s == 0) ? 16 : (s == 1) ? 8 : 4;
    endfunction

    function automatic int nvec(input int n, input int s);
        return (n + lanes(s) - 1) / lanes(s);
    endfunction

    function automatic logic [127:0] gen(input int seed, input int k, input int side);
        logic [127:0] v;
        logic [31:0]  x;
        if (seed == 0) begin
            return (side == 0) ? {128{1'b1}} : {16{8'h01}};
        end
        for (int w = 0; w < 4; w++) begin
            x = 32'(seed) * 32'h9E3779B1 + 32'(k) * 32'h7F4A7C15 + 32'(w + side*4) * 32'h94D049BB;
            x = x ^ (x >> 16);
            x = x * 32'h85EBCA6B;
            x = x ^ (x >> 13);
            v[32*w +: 32] = x;
        end
        return v;
    endfunction

    task automatic exp_vec(input logic [127:0] a, input logic [127:0] b, input int s,
                           input int rem, output logic [127:0] d, output logic [15:0] be);
        int bpl;
        logic [127:0] m, t;
        bpl = 16 / lanes(s);
        m = (128'h1 << (8*bpl)) - 128'h1;
        d = '0;
        be = '0;
        for (int i = 0; i < lanes(s); i++) begin
            if (i < rem) begin
                t = ((a >> (8*bpl*i)) + (b >> (8*bpl*i))) & m;
                d = d | (t << (8*bpl*i));
                be = be | (16'((1 << bpl) - 1) << (bpl*i));
            end
        end
    endtask

    task automatic mon(input int d, output int grp);
        int vk, eb, bpc;
        logic [127:0] ea, eb2, ed;
        logic [15:0]  ebe;
        logic [63:0]  gd, xd;
        logic [7:0]   gbe, xbe;
        logic         gv, gl;
        logic [1:0]   gb;
        vk = 0; eb = 0; grp = 0; bpc = d + 1;
        while (!(d == 0 ? stop0 : stop1)) begin
            @(negedge clk);
            gv = (d == 0) ? v0 : v1;
            if (gv) begin
                grp++;
                gd  = (d == 0) ? {32'b0, dt0} : dt1;
                gbe = (d == 0) ? {4'b0, be0} : be1;
                gl  = (d == 0) ? l0 : l1;
                gb  = (d == 0) ? bt0 : bt1;
                if (vk >= nvec(cur_n, cur_sz)) begin
                    chk(1'b0, "R6", "group beyond last vector", 64'(vk), 64'(nvec(cur_n, cur_sz)));
                end else begin
                    ea  = gen(cur_seed, vk, 0);
                    eb2 = gen(cur_seed, vk, 1);
                    exp_vec(ea, eb2, cur_sz, cur_n - vk*lanes(cur_sz), ed, ebe);
                    xd  = 64'(ed >> (32*eb));
                    xbe = 8'(ebe >> (4*eb));
                    if (bpc == 1) begin
                        xd[63:32] = '0;
                        xbe[7:4]  = '0;
                    end
                    chk(gd == xd, "R1", "lane sums", gd, xd);
                    chk(gbe == xbe, "R4/R5", "byte enables", 64'(gbe), 64'(xbe));
                    chk(gb == 2'(eb) && gl == (eb + bpc == 4), "R3", "beat index/last",
                        64'({gl, gb}), 64'({(eb + bpc == 4), 2'(eb)}));
                end
                eb += bpc;
                if (eb == 4) begin
                    eb = 0;
                    vk++;
                end
            end
        end
    endtask

    task automatic feed(input int d);
        int cyc, nis, lat, k;
        bit pend;
        logic dv, iv;
        cyc = 0; nis = 0; pend = 0;
        k = nvec(cur_n, cur_sz);
        while (1) begin
            @(negedge clk);
            cyc++;
            if (pend) begin
                if (d == 0) begin
                    a0 = gen(cur_seed, nis, 0);
                    b0 = gen(cur_seed, nis, 1);
                end else begin
                    a1 = gen(cur_seed, nis, 0);
                    b1 = gen(cur_seed, nis, 1);
                end
                pend = 0;
            end
            dv = (d == 0) ? dn0 : dn1;
            if (dv) break;
            iv = (d == 0) ? iss0 : iss1;
            if (iv) begin
                nis++;
                pend = 1;
            end
            if (cyc > 600) begin
                chk(1'b0, "R8", "done never raised", 64'(cyc), 64'(0));
                break;
            end
        end
        chk(nis == k, "R6", "vector steps issued", 64'(nis), 64'(k));
        // R7 and R8: start-to-done latency from back-to-back stepping
        lat = (cur_n == 0) ? 1 : 2 + (k - 1) * (4 / (d + 1));
        chk(cyc == lat, "R7", "cycles start to done", 64'(cyc), 64'(lat));
        @(negedge clk);
        dv = (d == 0) ? dn0 : dn1;
        chk(!dv, "R8", "done lasts one cycle", 64'(dv), 64'(0));
        repeat (5) @(negedge clk);
        if (d == 0) stop0 = 1'b1; else stop1 = 1'b1;
    endtask

    task automatic run(input int n, input int s, input int seed, input bit glitch);
        int k;
        cur_n = n; cur_sz = s; cur_seed = seed;
        stop0 = 1'b0; stop1 = 1'b0;
        k = nvec(n, s);
        @(negedge clk);
        a0 = gen(seed, 0, 0); b0 = gen(seed, 0, 1);
        a1 = a0; b1 = b0;
        cnt = 16'(n); sz = 2'(s); start = 1'b1;
        fork
            feed(0);
            feed(1);
            mon(0, g0);
            mon(1, g1);
            begin
                @(negedge clk);
                start = 1'b0;
                if (glitch) begin
                    // R9: a new request while running must be ignored
                    repeat (3) @(negedge clk);
                    start = 1'b1; cnt = 16'd3; sz = 2'd0;
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        join
        chk(g0 == k*4, "R2", "groups single-beat", 64'(g0), 64'(k*4));
        chk(g1 == k*2, glitch ? "R9" : "R2", "groups dual-beat", 64'(g1), 64'(k*2));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL R8 watchdog expired: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int nlist[15] = '{0, 1, 2, 3, 4, 5, 7, 8, 9, 15, 16, 17, 31, 33, 40};
        rst = 1'b1; start = 1'b0; cnt = '0; sz = '0;
        a0 = '0; b0 = '0; a1 = '0; b1 = '0;
        stop0 = 1'b0; stop1 = 1'b0;
        repeat (3) @(negedge clk);
        chk(!iss0 && !v0 && !dn0 && !iss1 && !v1 && !dn1, "R10", "outputs in reset",
            64'({iss0, v0, dn0, iss1, v1, dn1}), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(!iss0 && !v0 && !dn0 && !iss1 && !v1 && !dn1, "R10", "outputs after reset",
            64'({iss0, v0, dn0, iss1, v1, dn1}), 64'(0));
        for (int s = 0; s < 4; s++) begin
            foreach (nlist[i]) begin
                run(nlist[i], s, (nlist[i] % 3 == 0) ? 0 : nlist[i]*37 + s*11 + 5, 1'b0);
            end
        end
        run(40, 2, 91, 1'b1);
        run(40, 0, 0, 1'b1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule